// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block exposes a private register file to a byte-wide I/O bus through just two addresses. The host first writes a register number to the index address; that number stays latched. Later reads and writes of the data address are then forwarded to the downstream register file at the latched number. The block does not hold the register contents. It supplies the index, the write data and single-cycle read and write enables, and it returns the data the register file drives back.

A software lock guards the window. A single slot of the indirect space, the lock slot, is handled inside the block. Writing the key byte there opens the port, and writing any other byte closes it. While the port is closed, data accesses never reach the register file: reads return all ones and writes are dropped. Accesses to the lock slot itself are always served, so the port can always be reopened. The routing and trigger-mode registers that sit behind the port are outside this block.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is closed and the latched index is 0x00. A read of the index address returns 0x00, and a read of the data address with the index at the lock slot returns 0x00.
- R2: A write to the index address (default 0x22) stores the byte as the new index. It raises neither rf_we nor rf_re. A read of the index address returns the stored byte.
- R3: Writing the key 0xC5 through the data address (default 0x23) while the index is the lock slot 0x03 opens the port. A later read of the lock slot returns 0x01.
- R4: Writing any byte other than 0xC5 to the lock slot closes the port. A later read of the lock slot returns 0x00.
- R5: While the port is closed, a data-address write to any slot other than the lock slot keeps rf_we low. The register file keeps its earlier value.
- R6: While the port is closed, a data-address read of any slot other than the lock slot returns 0xFF and keeps rf_re low.
- R7: While the port is open, a data-address write raises rf_we in the same cycle, with rf_index equal to the latched index and rf_wdata equal to the written byte.
- R8: While the port is open, a data-address read raises rf_re in that cycle and returns rf_rdata unchanged on io_rdata.
- R9: The latched index stays the same across any number of data-address accesses until the index address is written again.
- R10: Reads and writes of the lock slot never raise rf_we or rf_re, whether the port is open or closed.
- R11: Reads of any other I/O address return 0xFF. Writes to any other I/O address change neither the index nor the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | 8 | Host read data, combinational while io_rd is high |
| rf_index | output | 8 | Latched index sent to the register file |
| rf_wdata | output | 8 | Write data sent to the register file |
| rf_we | output | 1 | Register-file write enable |
| rf_re | output | 1 | Register-file read enable |
| rf_rdata | input | 8 | Read data from the register file at rf_index |

## Verification
The hardest case to reach from the ports is a write that is dropped while the port is closed. Nothing on io_rdata shows it at the time. The stimulus writes a marker byte to slot 0x44 while the port is closed, opens the port with the key, then reads 0x44 back and expects the bench register file's cleared value instead of the marker. Near-miss keys and relocking from the open state are driven through the same lock slot, and the enables are sampled during each access.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    // Which host access hits the block in the current cycle
    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } cfg_hit_t;

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int IDX_PORT = 'h22,
    parameter int DAT_PORT = 'h23
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output cfg_hit_t          hit
);
    localparam logic [ADDR_W-1:0] IDX_A = IDX_PORT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DAT_PORT[ADDR_W-1:0];

    always_comb begin
        hit        = '0;
        hit.idx_wr = wr && (addr == IDX_A);
        hit.idx_rd = rd && (addr == IDX_A);
        hit.dat_wr = wr && (addr == DAT_A);
        hit.dat_rd = rd && (addr == DAT_A);
    end
endmodule

// File: rtl/cfgport_state.sv
module cfgport_state
    import cfgport_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LOCK_IDX = 'h03,
    parameter int KEY      = 'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_hit_t          hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] index_q,
    output logic              open_q
);
    localparam logic [DATA_W-1:0] LOCK_V = LOCK_IDX[DATA_W-1:0];
    localparam logic [DATA_W-1:0] KEY_V  = KEY[DATA_W-1:0];

    typedef struct packed {
        logic [DATA_W-1:0] index;
        logic              open;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit.idx_wr)
            st_d.index = wdata;
        if (hit.dat_wr && (st_q.index == LOCK_V))
            st_d.open = (wdata == KEY_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign index_q = st_q.index;
    assign open_q  = st_q.open;

    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.dat_wr && index_q == LOCK_V && wdata == KEY_V) |=> open_q);
    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.dat_wr && index_q == LOCK_V && wdata != KEY_V) |=> !open_q);
    assert_index_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit.idx_wr |=> $stable(index_q));
    assert_lock_only_by_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit.dat_wr && index_q == LOCK_V) |=> $stable(open_q));
endmodule

// File: rtl/cfgport_access.sv
module cfgport_access
    import cfgport_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LOCK_IDX = 'h03
) (
    input  cfg_hit_t          hit,
    input  logic [DATA_W-1:0] index_q,
    input  logic              open_q,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic              rf_re,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] io_rdata
);
    localparam logic [DATA_W-1:0] LOCK_V = LOCK_IDX[DATA_W-1:0];
    localparam logic [DATA_W-1:0] IDLE_V = '1;

    logic at_lock;
    logic pass;

    always_comb begin
        at_lock  = (index_q == LOCK_V);
        pass     = open_q && !at_lock;
        rf_we    = hit.dat_wr && pass;
        rf_re    = hit.dat_rd && pass;
        rf_wdata = wdata;
        io_rdata = IDLE_V;
        if (hit.idx_rd)
            io_rdata = index_q;
        else if (hit.dat_rd) begin
            if (at_lock)     io_rdata = {{(DATA_W-1){1'b0}}, open_q};
            else if (open_q) io_rdata = rf_rdata;
        end
    end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import cfgport_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int IDX_PORT = 'h22,
    parameter int DAT_PORT = 'h23,
    parameter int LOCK_IDX = 'h03,
    parameter int KEY      = 'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] rf_index,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam logic [DATA_W-1:0] LOCK_V = LOCK_IDX[DATA_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A  = DAT_PORT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] IDX_A  = IDX_PORT[ADDR_W-1:0];

    cfg_hit_t          hit;
    logic [DATA_W-1:0] index_q;
    logic              open_q;

    cfgport_decode #(.ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)) u_dec (
        .addr(io_addr), .rd(io_rd), .wr(io_wr), .hit(hit)
    );

    cfgport_state #(.DATA_W(DATA_W), .LOCK_IDX(LOCK_IDX), .KEY(KEY)) u_st (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wdata(io_wdata),
        .index_q(index_q), .open_q(open_q)
    );

    cfgport_access #(.DATA_W(DATA_W), .LOCK_IDX(LOCK_IDX)) u_acc (
        .hit(hit), .index_q(index_q), .open_q(open_q), .wdata(io_wdata),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_re(rf_re),
        .rf_wdata(rf_wdata), .io_rdata(io_rdata)
    );

    assign rf_index = index_q;

    assert_closed_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |-> !rf_we);
    assert_closed_read_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == DAT_A && !open_q && rf_index != LOCK_V) |-> (io_rdata == '1 && !rf_re));
    assert_lock_slot_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_index == LOCK_V) |-> !(rf_we || rf_re));
    assert_index_port_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == IDX_A) |-> !(rf_we || rf_re));
endmodule

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0, io_wdata = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_rdata, rf_index, rf_wdata, rf_rdata;
    logic       rf_we, rf_re;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    keyed_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rf_index(rf_index),
        .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
    );

    // Bench model of the downstream register file
    logic [7:0] rf_mem [256];
    assign rf_rdata = rf_mem[rf_index];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) rf_mem[i] <= 8'h00;
        end else if (rf_we) begin
            rf_mem[rf_index] <= rf_wdata;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    logic       s_we, s_re;
    logic [7:0] s_idx, s_wd, s_rd;

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        s_we = rf_we; s_re = rf_re; s_idx = rf_index; s_wd = rf_wdata;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        s_rd = io_rdata; s_re = rf_re; s_we = rf_we;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // {is_read, addr, data, expected}
    localparam int NV = 31;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h22, 8'h00, 8'h00},  // R1 index after reset
        {1'b0, 8'h22, 8'h03, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'h00},  // R1 closed after reset
        {1'b0, 8'h22, 8'h44, 8'h00},
        {1'b0, 8'h23, 8'h77, 8'h00},  // R5 dropped write
        {1'b1, 8'h23, 8'h00, 8'hFF},  // R6
        {1'b0, 8'h22, 8'h03, 8'h00},
        {1'b0, 8'h23, 8'hC5, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'h01},  // R3
        {1'b0, 8'h22, 8'h44, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'h00},  // R5 marker absent
        {1'b0, 8'h22, 8'h42, 8'h00},
        {1'b0, 8'h23, 8'h5A, 8'h00},  // R7
        {1'b1, 8'h23, 8'h00, 8'h5A},  // R8
        {1'b1, 8'h22, 8'h00, 8'h42},  // R2 readback
        {1'b0, 8'h22, 8'h43, 8'h00},
        {1'b0, 8'h23, 8'hA5, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'hA5},
        {1'b0, 8'h23, 8'h3C, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'h3C},  // R9 index held
        {1'b1, 8'h22, 8'h00, 8'h43},  // R9
        {1'b0, 8'h10, 8'h99, 8'h00},  // R11 stray write
        {1'b1, 8'h10, 8'h00, 8'hFF},  // R11
        {1'b1, 8'h22, 8'h00, 8'h43},  // R11 index untouched
        {1'b0, 8'h22, 8'h03, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'h01},  // R11 still open
        {1'b0, 8'h23, 8'hC4, 8'h00},  // R4 near-miss key
        {1'b1, 8'h23, 8'h00, 8'h00},  // R4
        {1'b0, 8'h22, 8'h43, 8'h00},
        {1'b1, 8'h23, 8'h00, 8'hFF},  // R6 after relock
        {1'b1, 8'h22, 8'h00, 8'h43}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                io_read(VEC[i][23:16]);
                check($sformatf("R1-table vector %0d", i), s_rd, VEC[i][7:0]);
            end else begin
                io_write(VEC[i][23:16], VEC[i][15:8]);
            end
        end

        // R2: index write makes no register-file access
        io_write(8'h22, 8'h42);
        check("R2 index write rf_we", {7'b0, s_we}, 8'h00);
        check("R2 index write rf_re", {7'b0, s_re}, 8'h00);

        // R5 / R6: closed port strobes
        io_write(8'h23, 8'h11);
        check("R5 closed rf_we", {7'b0, s_we}, 8'h00);
        io_read(8'h23);
        check("R6 closed rf_re", {7'b0, s_re}, 8'h00);
        check("R6 closed data", s_rd, 8'hFF);

        // R10: lock slot accesses, closed then open
        io_write(8'h22, 8'h03);
        io_write(8'h23, 8'hC5);
        check("R10 key write rf_we", {7'b0, s_we}, 8'h00);
        io_read(8'h23);
        check("R10 lock read rf_re", {7'b0, s_re}, 8'h00);
        check("R3 lock reads open", s_rd, 8'h01);

        // R7 / R8: open port strobes
        io_write(8'h22, 8'h44);
        io_write(8'h23, 8'h96);
        check("R7 rf_we", {7'b0, s_we}, 8'h01);
        check("R7 rf_index", s_idx, 8'h44);
        check("R7 rf_wdata", s_wd, 8'h96);
        io_read(8'h23);
        check("R8 rf_re", {7'b0, s_re}, 8'h01);
        check("R8 data", s_rd, 8'h96);

        // R10: relock write while open reaches nothing
        io_write(8'h22, 8'h03);
        io_write(8'h23, 8'h00);
        check("R10 relock rf_we", {7'b0, s_we}, 8'h00);
        io_read(8'h23);
        check("R4 lock reads closed", s_rd, 8'h00);

        // R1: reset mid-run restores closed state and index 0
        io_write(8'h23, 8'hC5);
        io_write(8'h22, 8'h55);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        io_read(8'h22);
        check("R1 index after reset", s_rd, 8'h00);
        io_write(8'h22, 8'h03);
        io_read(8'h23);
        check("R1 closed after reset", s_rd, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule